// File: doc/BRIEF.md
# Power-Management Event Collector with Interrupt Output

This unit gathers power-management events into a sticky 16-bit status register and raises a level-sensitive system control interrupt (`sci`) while any enabled event from a fixed group of four is pending. Software reaches the unit through a 64-byte I/O window. The window base comes from a 32-bit configuration word. A separate configuration byte switches the window on or off. Inside the window there are a status register, an enable register, a general control register and a free-running count that can only be read.

Three of the events in the group come from outside on the `evt_set` pulses. The fourth is internal: the most significant bit of the free-running count toggles. A four-state machine tracks that timer event. In `TMR_OFF` the timer enable is clear and the status is clear. In `TMR_ARMED` the enable is set and the status is clear. In `TMR_FIRED` both are set. In `TMR_HELD` the status is still set but the enable has been cleared.

The transitions are as follows. `TMR_OFF` goes to `TMR_ARMED` when the enable is set, or straight to `TMR_FIRED` if a toggle comes in the same cycle. `TMR_ARMED` goes to `TMR_FIRED` on a toggle, or to `TMR_OFF` when the enable is dropped. `TMR_FIRED` goes to `TMR_ARMED` or `TMR_OFF` when a clear is written, and to `TMR_HELD` when the enable is dropped. `TMR_HELD` goes to `TMR_OFF` or `TMR_ARMED` when cleared, and back to `TMR_FIRED` when the enable is set again.

Top module: `pm_evt_sci`

## Requirements
- R1: After reset, the status, enable and control registers read 0 and `sci` is low.
- R2: The window base is `cfg_base & 0xFFC0`. An address hits (`io_hit` = 1) only when `cfg_en[0]` is 1 and the address lies in `[base, base+63]`. On a miss, `io_rdata` is 0 and writes are ignored.
- R3: The enable register (offset 0x02) and the control register (offset 0x04) are 16-bit read/write. Offsets with no register read 0.
- R4: Status bits 15..1 (offset 0x00) are set by a one-cycle pulse on `evt_set[i]` and stay set. `evt_set[0]` has no effect.
- R5: Writing 1 to a status bit clears it and writing 0 leaves it. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: One clock after the status and enable registers update, `sci` is high exactly when `status & enable` has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC) set.
- R7: Status bits outside that group never raise `sci`, even when they are enabled.
- R8: The CNT_W-bit count advances by one every clock. It reads as bits 15:0 at offset 0x08 and as bits 31:16, zero-extended, at offset 0x0A. Writes to it are ignored.
- R9: Status bit 0 sets at the clock edge where count bits CNT_W-2..0 are all ones (bit CNT_W-1 toggles), provided enable bit 0 is 1.
- R10: While enable bit 0 is 0, toggles do not set status bit 0. Clearing enable bit 0 after the bit has fired leaves it set until it is written clear.
- R11: Clearing status bit 0 while enable bit 0 is 1 re-arms the timer, and the next toggle sets the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration word holding the window base |
| cfg_en | input | 8 | Configuration byte; bit 0 turns the window on |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for `io_addr`, combinational |
| io_hit | output | 1 | `io_addr` falls inside the enabled window |
| evt_set | input | 16 | Event pulses that set status bits 15..1 |
| sci | output | 1 | Level interrupt |

## Verification
The hardest condition to reach from the ports is the timer toggle, because it happens at exactly one edge in 2^(CNT_W-1). The bench builds the block with a narrow count. After arming, it reads the count, works out how many edges remain until the low bits are all ones, and checks that status bit 0 is still clear one edge before that point and set at it. It then repeats this after a clear to cover re-arming, and it drops the enable after a fire to reach `TMR_HELD`.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 16;

    // Byte offsets inside the window
    localparam int OFS_STS    = 'h00;
    localparam int OFS_EN     = 'h02;
    localparam int OFS_CTL    = 'h04;
    localparam int OFS_CNT_LO = 'h08;
    localparam int OFS_CNT_HI = 'h0A;

    // Event bit positions shared by status and enable
    localparam int BIT_TMR    = 0;
    localparam int BIT_GLOCK  = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;

    localparam logic [DATA_W-1:0] SCI_GROUP =
        (DATA_W'(1) << BIT_TMR)    | (DATA_W'(1) << BIT_GLOCK) |
        (DATA_W'(1) << BIT_PWRBTN) | (DATA_W'(1) << BIT_RTC);

    typedef enum logic [1:0] {
        TMR_OFF   = 2'd0,
        TMR_ARMED = 2'd1,
        TMR_FIRED = 2'd2,
        TMR_HELD  = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
    import pm_evt_pkg::*;
#(
    parameter int          WIN_BITS  = 6,
    parameter logic [31:0] BASE_MASK = 32'h0000_FFC0
) (
    input  logic [31:0]         cfg_base,
    input  logic [7:0]          cfg_en,
    input  logic [ADDR_W-1:0]   io_addr,
    output logic                hit,
    output logic [WIN_BITS-1:0] ofs
);
    logic [ADDR_W-1:0] base;

    assign base = cfg_base[ADDR_W-1:0] & BASE_MASK[ADDR_W-1:0];
    assign hit  = cfg_en[0] && (io_addr[ADDR_W-1:WIN_BITS] == base[ADDR_W-1:WIN_BITS]);
    assign ofs  = io_addr[WIN_BITS-1:0];
endmodule

// File: rtl/pm_tmr_fsm.sv
module pm_tmr_fsm
    import pm_evt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             tmr_clr,
    output logic [CNT_W-1:0] count,
    output logic             tog,
    output logic             tmr_sts
);
    tmr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    assign count = cnt_q;
    // Next increment flips the top bit
    assign tog   = &cnt_q[CNT_W-2:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_OFF;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_OFF: begin
                if (tmr_en) state_d = tog ? TMR_FIRED : TMR_ARMED;
            end
            TMR_ARMED: begin
                if (!tmr_en)  state_d = TMR_OFF;
                else if (tog) state_d = TMR_FIRED;
            end
            TMR_FIRED: begin
                if (tmr_clr)      state_d = tmr_en ? TMR_ARMED : TMR_OFF;
                else if (!tmr_en) state_d = TMR_HELD;
            end
            TMR_HELD: begin
                if (tmr_clr)     state_d = tmr_en ? TMR_ARMED : TMR_OFF;
                else if (tmr_en) state_d = TMR_FIRED;
            end
            default: state_d = TMR_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TMR_FIRED, TMR_HELD: tmr_sts = 1'b1;
            default:             tmr_sts = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int WIN_BITS = 6,
    parameter int CNT_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic                io_wr,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   evt_set,
    input  logic                tmr_sts,
    input  logic [CNT_W-1:0]    count,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W-1:0]   en_q,
    output logic [DATA_W-1:0]   sts_all,
    output logic                tmr_clr,
    output logic                sci
);
    logic wr_any, wr_sts, wr_en, wr_ctl;
    logic [DATA_W-1:1] sts_q;
    logic [DATA_W-1:0] ctl_q;
    logic [31:0]       cnt_ext;
    logic              sci_q;

    assign wr_any = hit & io_wr;
    assign wr_sts = wr_any && (ofs == WIN_BITS'(OFS_STS));
    assign wr_en  = wr_any && (ofs == WIN_BITS'(OFS_EN));
    assign wr_ctl = wr_any && (ofs == WIN_BITS'(OFS_CTL));

    // Sticky event bits with write-one-to-clear; a set pulse wins
    for (genvar gi = 1; gi < DATA_W; gi++) begin : g_sts
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   bit_q <= 1'b0;
            else if (evt_set[gi])         bit_q <= 1'b1;
            else if (wr_sts && wdata[gi]) bit_q <= 1'b0;
        end
        assign sts_q[gi] = bit_q;
    end

    assign sts_all = {sts_q, tmr_sts};
    assign tmr_clr = wr_sts & wdata[BIT_TMR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_en)  en_q  <= wdata;
            if (wr_ctl) ctl_q <= wdata;
        end
    end

    // Level interrupt, registered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sci_q <= 1'b0;
        else        sci_q <= |(sts_all & en_q & SCI_GROUP);
    end
    assign sci = sci_q;

    assign cnt_ext = 32'(count);

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                WIN_BITS'(OFS_STS):    rdata = sts_all;
                WIN_BITS'(OFS_EN):     rdata = en_q;
                WIN_BITS'(OFS_CTL):    rdata = ctl_q;
                WIN_BITS'(OFS_CNT_LO): rdata = cnt_ext[15:0];
                WIN_BITS'(OFS_CNT_HI): rdata = cnt_ext[31:16];
                default:               rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
    import pm_evt_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          WIN_BITS  = 6,
    parameter logic [31:0] BASE_MASK = 32'h0000_FFC0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_base,
    input  logic [7:0]  cfg_en,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata,
    output logic        io_hit,
    input  logic [15:0] evt_set,
    output logic        sci
);
    logic [WIN_BITS-1:0] ofs;
    logic [DATA_W-1:0]   en_reg, sts_all;
    logic [CNT_W-1:0]    count;
    logic                tmr_tog, tmr_sts, tmr_clr;

    pm_win_decode #(.WIN_BITS(WIN_BITS), .BASE_MASK(BASE_MASK)) u_dec (
        .cfg_base (cfg_base),
        .cfg_en   (cfg_en),
        .io_addr  (io_addr),
        .hit      (io_hit),
        .ofs      (ofs)
    );

    pm_tmr_fsm #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_en  (en_reg[BIT_TMR]),
        .tmr_clr (tmr_clr),
        .count   (count),
        .tog     (tmr_tog),
        .tmr_sts (tmr_sts)
    );

    pm_evt_regs #(.WIN_BITS(WIN_BITS), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (io_hit),
        .io_wr   (io_wr),
        .ofs     (ofs),
        .wdata   (io_wdata),
        .evt_set (evt_set),
        .tmr_sts (tmr_sts),
        .count   (count),
        .rdata   (io_rdata),
        .en_q    (en_reg),
        .sts_all (sts_all),
        .tmr_clr (tmr_clr),
        .sci     (sci)
    );
endmodule

// File: rtl/pm_evt_sci_chk.sv
module pm_evt_sci_chk
    import pm_evt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cfg_en,
    input logic        io_hit,
    input logic        sci,
    input logic [15:0] sts_all,
    input logic [15:0] en_reg,
    input logic [15:0] evt_set,
    input logic        tmr_tog
);
    // R2
    win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en[0] |-> !io_hit);

    // R6
    sci_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_all & en_reg & SCI_GROUP)) |=> sci);

    // R7
    sci_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts_all & en_reg & SCI_GROUP)) |=> !sci);

    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set[15:1]) |=> ((sts_all[15:1] & $past(evt_set[15:1])) == $past(evt_set[15:1])));

    // R9
    tmr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_reg[BIT_TMR] && !sts_all[BIT_TMR] && tmr_tog) |=> sts_all[BIT_TMR]);

    // R10
    tmr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_reg[BIT_TMR] && !sts_all[BIT_TMR]) |=> !sts_all[BIT_TMR]);
endmodule

bind pm_evt_sci pm_evt_sci_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .io_hit  (io_hit),
    .sci     (sci),
    .sts_all (sts_all),
    .en_reg  (en_reg),
    .evt_set (evt_set),
    .tmr_tog (tmr_tog)
);

// File: tb/pm_evt_sci_tb.sv
module pm_evt_sci_tb;
    localparam int TB_CNT_W = 10;
    localparam int HALF     = 1 << (TB_CNT_W - 1);
    localparam logic [15:0] B = 16'h5680;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_EV = 3'd2, OP_SC = 3'd3, OP_HT = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, B,          16'h0000, 4'd1},  // R1
        '{OP_RD, B+16'h2,    16'h0000, 4'd1},  // R1
        '{OP_RD, B+16'h4,    16'h0000, 4'd1},  // R1
        '{OP_SC, 16'h0,      16'h0000, 4'd1},  // R1
        '{OP_WR, B+16'h4,    16'hA5C3, 4'd3},  // R3
        '{OP_RD, B+16'h4,    16'hA5C3, 4'd3},  // R3
        '{OP_RD, B+16'h6,    16'h0000, 4'd3},  // R3 unmapped
        '{OP_HT, B+16'h3F,   16'h0001, 4'd2},  // R2 last byte
        '{OP_HT, B+16'h40,   16'h0000, 4'd2},  // R2 just above
        '{OP_HT, B-16'h1,    16'h0000, 4'd2},  // R2 just below
        '{OP_EV, 16'h0,      16'h0010, 4'd4},  // R4
        '{OP_RD, B,          16'h0010, 4'd4},  // R4
        '{OP_WR, B+16'h2,    16'h0010, 4'd7},  // R7
        '{OP_SC, 16'h0,      16'h0000, 4'd7},  // R7 bit 4 not in group
        '{OP_EV, 16'h0,      16'h0001, 4'd4},  // R4 bit 0 pulse
        '{OP_RD, B,          16'h0010, 4'd4},  // R4 no effect
        '{OP_EV, 16'h0,      16'h0020, 4'd6},  // R6
        '{OP_SC, 16'h0,      16'h0000, 4'd6},  // R6 not enabled
        '{OP_WR, B+16'h2,    16'h0030, 4'd6},  // R6
        '{OP_SC, 16'h0,      16'h0001, 4'd6},  // R6 global lock
        '{OP_WR, B,          16'h0000, 4'd5},  // R5
        '{OP_RD, B,          16'h0030, 4'd5},  // R5 zero write
        '{OP_WR, B,          16'h0020, 4'd5},  // R5
        '{OP_RD, B,          16'h0010, 4'd5},  // R5 one clears
        '{OP_SC, 16'h0,      16'h0000, 4'd6},  // R6
        '{OP_EV, 16'h0,      16'h0500, 4'd6},  // R6
        '{OP_WR, B+16'h2,    16'h0400, 4'd6},  // R6
        '{OP_SC, 16'h0,      16'h0001, 4'd6},  // R6 RTC
        '{OP_RD, B,          16'h0510, 4'd4},  // R4
        '{OP_WR, B+16'h2,    16'h0100, 4'd6},  // R6
        '{OP_SC, 16'h0,      16'h0001, 4'd6},  // R6 power button
        '{OP_WR, B,          16'h0510, 4'd5},  // R5
        '{OP_RD, B,          16'h0000, 4'd5},  // R5
        '{OP_SC, 16'h0,      16'h0000, 4'd6},  // R6
        '{OP_WR, B+16'h2,    16'h0000, 4'd3},  // R3
        '{OP_RD, B+16'h2,    16'h0000, 4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = 32'h1234_5687;
    logic [7:0]  cfg_en = 8'h01;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_hit;
    logic [15:0] evt_set = '0;
    logic        sci;

    int  nvec = 0;
    int  nmis = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pm_evt_sci #(.CNT_W(TB_CNT_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_base (cfg_base),
        .cfg_en   (cfg_en),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .io_hit   (io_hit),
        .evt_set  (evt_set),
        .sci      (sci)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic wait_fire(input string req);
        logic [15:0] c, s;
        int d;
        rd(B + 16'h8, c);
        d = (HALF - 1) - (int'(c) % HALF);
        repeat (d) step();
        rd(B, s);
        chk({req, " before toggle"}, s, 16'h0000);
        step();
        rd(B, s);
        chk({req, " at toggle"}, s, 16'h0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nvec++;
            nmis++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_WR: wr(VECS[i].addr, VECS[i].data);
                OP_RD: begin
                    rd(VECS[i].addr, v);
                    chk(tag, v, VECS[i].data);
                end
                OP_EV: begin
                    evt_set = VECS[i].data;
                    step();
                    evt_set = '0;
                end
                OP_SC: begin
                    step();
                    chk(tag, {15'b0, sci}, VECS[i].data);
                end
                default: begin
                    io_addr = VECS[i].addr;
                    #1;
                    chk(tag, {15'b0, io_hit}, VECS[i].data);
                end
            endcase
        end

        // R5: set and clear on the same bit in one cycle
        io_addr = B; io_wdata = 16'h0002; io_wr = 1'b1; evt_set = 16'h0002;
        step();
        io_wr = 1'b0; evt_set = '0;
        rd(B, v); chk("R5 set wins", v, 16'h0002);
        wr(B, 16'h0002);
        rd(B, v); chk("R5 cleared", v, 16'h0000);

        // R2: window off, then relocated
        cfg_en = 8'hFE;
        wr(B + 16'h4, 16'h1111);
        io_addr = B; #1; chk("R2 window off hit", {15'b0, io_hit}, 16'h0000);
        rd(B + 16'h4, v); chk("R2 window off read", v, 16'h0000);
        cfg_en = 8'h01;
        rd(B + 16'h4, v); chk("R2 write ignored while off", v, 16'hA5C3);
        cfg_base = 32'hABCD_0FFF;
        rd(16'h0FC4, v); chk("R2 relocated read", v, 16'hA5C3);
        rd(B + 16'h4, v); chk("R2 old base misses", v, 16'h0000);
        cfg_base = 32'h1234_5687;

        // R8: count runs, writes ignored
        rd(B + 16'h8, c1);
        wr(B + 16'h8, 16'h0155);
        rd(B + 16'h8, v);
        chk("R8 count advances", v, 16'((int'(c1) + 1) % (2 * HALF)));
        rd(B + 16'hA, v); chk("R8 high half", v, 16'h0000);

        // R9: timer fires at the toggle edge
        wr(B + 16'h2, 16'h0001);
        wait_fire("R9");
        step();
        chk("R6 timer sci", {15'b0, sci}, 16'h0001);

        // R11: clear re-arms
        wr(B, 16'h0001);
        rd(B, v); chk("R11 cleared", v, 16'h0000);
        wait_fire("R11");

        // R10: disable after firing holds status
        wr(B + 16'h2, 16'h0000);
        step();
        step();
        rd(B, v); chk("R10 held status", v, 16'h0001);
        chk("R10 sci low when disabled", {15'b0, sci}, 16'h0000);
        wr(B, 16'h0001);
        rd(B, v); chk("R10 cleared from held", v, 16'h0000);
        repeat (2 * HALF + 20) step();
        rd(B, v); chk("R10 no fire while disabled", v, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule